// File: doc/BRIEF.md
# Packet Buffer ECC Monitor and Error Injector

This block sits next to a packet buffer RAM that holds transmit and receive lines, each line being either a header line or a data line. It watches the RAM's write and read strobes. On a write it can invert up to two chosen bits of the outgoing word, so that the ECC path downstream can be tested. It takes one-cycle correctable and uncorrectable error pulses from the ECC decoder and counts each kind. When asked, it latches the address of the first read that fails.

Software reaches two 32-bit registers through a simple register port: a status register and an injection register. Write data is taken on a clock edge. Read data is combinational from the selected register, and a read of the status register clears both error counts at the next edge. The SECDED encoder and decoder, the RAM and its pointers sit outside the block. The decoder's verdict arrives as two error flags that line up with the read address.

Top module: `ecc_err_mon`

## Requirements
- R1: After a synchronous active-low reset, both registers read as all zero and no write data is altered.
- R2: Status bits 7:0 count correctable error pulses. A pulse is taken only while the enable bit (status bit 16) is 1. Each pulse adds one, and the count holds at 0xFF instead of wrapping.
- R3: Status bits 15:8 count uncorrectable error pulses under the same rules as R2: enable-gated, one per pulse, holding at 0xFF.
- R4: A read of the status register (reg_sel = 0) clears both counts at the next edge. A counted pulse in that same cycle leaves a count of 1 instead of 0.
- R5: Status bits 16 (enable) and 17 (stop-on-first-error) are read/write. Status bits 19:18 and injection bits 15:4 always read 0. A register write never changes the count fields or the address field.
- R6: A failing read is a cycle with mem_rd = 1, enable = 1 and either error pulse high. When stop-on-first-error (bit 17) is 1, the first failing read copies mem_addr into status bits 31:20. Later failures leave that value untouched until bit 17 is written to 0, which re-arms the capture. The captured value stays readable after bit 17 is cleared.
- R7: Injection bits 3:0 arm a one-shot. The target line type is selected by the index {mem_is_rx, mem_is_data}: bit 0 is Tx header, bit 1 is Tx data, bit 2 is Rx header and bit 3 is Rx data. A write to the armed line type consumes the bit, which then clears if addr_mode = 0 and stays set if addr_mode = 1. A register write to the injection register in the same cycle takes priority over the clear.
- R8: On a write that hits an armed bit, mem_wdata_out equals mem_wdata with the bits at positions inj[23:16] and inj[31:24] inverted. A position of 0xFF, or one not below DATA_W, inverts nothing. Two equal positions invert that single bit once. Every other write passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read clears the counts) |
| reg_sel | input | 1 | 0 selects the status register, 1 selects the injection register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| addr_mode | input | 1 | 1 keeps inject bits armed after use |
| mem_wr | input | 1 | Packet buffer write strobe |
| mem_rd | input | 1 | Packet buffer read strobe |
| mem_is_rx | input | 1 | 1 for the Rx buffer, 0 for the Tx buffer |
| mem_is_data | input | 1 | 1 for a data line, 0 for a header line |
| mem_addr | input | ADDR_W | Line address of the current access |
| mem_wdata | input | DATA_W | Write word from the ECC encoder |
| mem_wdata_out | output | DATA_W | Write word to the RAM, possibly corrupted |
| err_corr | input | 1 | Correctable error pulse for the current read |
| err_uncorr | input | 1 | Uncorrectable error pulse for the current read |

## Verification
A wrong count or a missed saturation shows up in reg_rdata on the first cycle after the error pulse that went wrong. The same holds for an enable gate that leaks. A stale capture flag shows as an address field that changes when it should hold, or holds when it should change, one cycle after the failing read. An inject bit that was never consumed, or was consumed twice, shows in the same cycle in mem_wdata_out of the next matching write, and one cycle later in the injection register's low bits. Comparing against a reference model on every clock therefore catches a fault within one cycle of the first stimulus that exposes it.

// File: rtl/ecc_mon_pkg.sv
// Package: register layouts shared by the ECC monitor modules.
// Assumes both registers are 32 bits wide. Field positions are software-visible.
package ecc_mon_pkg;
    localparam int CNT_W   = 8;
    localparam int LFA_W   = 12;
    localparam int NUM_INJ = 4;
    localparam int POS_W   = 8;

    typedef struct packed {
        logic [LFA_W-1:0] lfa;
        logic [1:0]       rsv;
        logic             sofe;
        logic             en;
        logic [CNT_W-1:0] ucnt;
        logic [CNT_W-1:0] ccnt;
    } status_t;

    typedef struct packed {
        logic [POS_W-1:0]   pos2;
        logic [POS_W-1:0]   pos1;
        logic [11:0]        rsv;
        logic [NUM_INJ-1:0] arm;
    } inject_t;
endpackage

// File: rtl/err_sat_cnt.sv
// Saturating error counter with clear-on-read.
// Assumes hit_i is a one-cycle pulse per error. A clear wins over the count but
// keeps a coincident hit, so the result is 1.
module err_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    // Count up to MAXV, or restart from the coincident hit on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (clr_i)
            cnt_o <= hit_i ? W'(1) : '0;
        else if (hit_i && cnt_o != MAXV)
            cnt_o <= cnt_o + W'(1);
    end

    // R2
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == MAXV && !clr_i) |=> cnt_o == MAXV);
    // R4
    clr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit_i) |=> cnt_o == '0);
endmodule

// File: rtl/fail_addr_cap.sv
// Stop-on-first-error failing-address capture.
// Assumes fail_i is already qualified by enable and the read strobe. Once an
// address is held, it stays until sofe_i drops, which re-arms the capture.
module fail_addr_cap #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sofe_i,
    input  logic          fail_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] lfa_o
);
    logic locked;

    // Latch the first failing address while the mode is on, and re-arm when it is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            lfa_o  <= '0;
        end else if (!sofe_i) begin
            locked <= 1'b0;
        end else if (fail_i && !locked) begin
            locked <= 1'b1;
            lfa_o  <= addr_i;
        end
    end

    // R6
    lfa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked || !sofe_i || !fail_i) |=> $stable(lfa_o));
endmodule

// File: rtl/inj_ctrl.sv
// One-shot error injection on packet buffer writes.
// Assumes a write targets exactly one line type, given by {is_rx, is_data}. It
// holds the arm bits and two bit positions and builds an XOR mask of up to two bits.
module inj_ctrl
    import ecc_mon_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_reg_i,
    input  logic [31:0]   wdata_i,
    input  logic          addr_mode_i,
    input  logic          mem_wr_i,
    input  logic          is_rx_i,
    input  logic          is_data_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_o,
    output inject_t       reg_o
);
    localparam logic [POS_W-1:0] NO_POS = {POS_W{1'b1}};

    logic [NUM_INJ-1:0] arm;
    logic [POS_W-1:0]   pos1, pos2;
    logic [1:0]         idx;
    logic               hit;
    logic [DW-1:0]      mask;

    assign idx = {is_rx_i, is_data_i};
    assign hit = mem_wr_i && arm[idx];

    // One mask bit per data bit. Equal positions still give a single flip.
    for (genvar i = 0; i < DW; i++) begin : g_mask
        assign mask[i] = hit && ((pos1 != NO_POS && pos1 == POS_W'(i)) ||
                                 (pos2 != NO_POS && pos2 == POS_W'(i)));
    end

    assign data_o = data_i ^ mask;

    // Register writes load the arm bits and positions, and a hit consumes its bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm  <= '0;
            pos1 <= '0;
            pos2 <= '0;
        end else if (wr_reg_i) begin
            arm  <= wdata_i[NUM_INJ-1:0];
            pos1 <= wdata_i[23:16];
            pos2 <= wdata_i[31:24];
        end else if (hit && !addr_mode_i) begin
            arm[idx] <= 1'b0;
        end
    end

    assign reg_o = '{pos2: pos2, pos1: pos1, rsv: '0, arm: arm};

    // R7
    inject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_reg_i && (!mem_wr_i || addr_mode_i)) |=> $stable(arm));
    // R8
    flip_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(data_o ^ data_i) <= 2);
    // R8
    flip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_i |-> data_o == data_i);
endmodule

// File: rtl/ecc_err_mon.sv
// Top: ECC error monitor and injector for a packet buffer.
// Holds the status register (counts, enable, stop-on-first-error and captured
// address) and the injection register. Read data is combinational, and a
// status read clears the counts at the next edge.
module ecc_err_mon
    import ecc_mon_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = LFA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              addr_mode,
    input  logic              mem_wr,
    input  logic              mem_rd,
    input  logic              mem_is_rx,
    input  logic              mem_is_data,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] mem_wdata_out,
    input  logic              err_corr,
    input  logic              err_uncorr
);
    logic             en_q, sofe_q;
    logic             stat_wr, stat_rd, inj_wr;
    logic [CNT_W-1:0] ccnt, ucnt;
    logic [LFA_W-1:0] lfa;
    status_t          stat;
    inject_t          inj;
    logic             unused_wbits;

    assign stat_wr = reg_wr && !reg_sel;
    assign stat_rd = reg_rd && !reg_sel;
    assign inj_wr  = reg_wr && reg_sel;
    assign unused_wbits = ^{reg_wdata[15:0], reg_wdata[31:18]};

    // Control bits of the status register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            sofe_q <= 1'b0;
        end else if (stat_wr) begin
            en_q   <= reg_wdata[16];
            sofe_q <= reg_wdata[17];
        end
    end

    err_sat_cnt #(.W(CNT_W)) u_corr (
        .clk(clk), .rst_n(rst_n), .hit_i(en_q && err_corr),
        .clr_i(stat_rd), .cnt_o(ccnt));

    err_sat_cnt #(.W(CNT_W)) u_uncorr (
        .clk(clk), .rst_n(rst_n), .hit_i(en_q && err_uncorr),
        .clr_i(stat_rd), .cnt_o(ucnt));

    fail_addr_cap #(.AW(LFA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .sofe_i(sofe_q),
        .fail_i(en_q && mem_rd && (err_corr || err_uncorr)),
        .addr_i(LFA_W'(mem_addr)), .lfa_o(lfa));

    inj_ctrl #(.DW(DATA_W)) u_inj (
        .clk(clk), .rst_n(rst_n), .wr_reg_i(inj_wr), .wdata_i(reg_wdata),
        .addr_mode_i(addr_mode), .mem_wr_i(mem_wr), .is_rx_i(mem_is_rx),
        .is_data_i(mem_is_data), .data_i(mem_wdata), .data_o(mem_wdata_out),
        .reg_o(inj));

    assign stat = '{lfa: lfa, rsv: 2'b00, sofe: sofe_q, en: en_q, ucnt: ucnt, ccnt: ccnt};

    // Register read mux.
    always_comb begin
        reg_rdata = reg_sel ? 32'(inj) : 32'(stat);
    end

    // R5
    cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !stat_rd && !err_corr && !err_uncorr) |=> ($stable(ccnt) && $stable(ucnt)));
    // R2
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !stat_rd) |=> ($stable(ccnt) && $stable(ucnt)));
endmodule

// File: tb/ecc_err_mon_tb.sv
// Bench: a behavioural reference model is stepped with the DUT and compared every cycle.
module ecc_err_mon_tb;
    localparam int DW = 64;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        b_wr = 0, b_rd = 0, b_sel = 0, b_am = 0;
    logic [31:0] b_wd = '0;
    logic        b_mw = 0, b_mr = 0, b_rx = 0, b_dt = 0, b_ec = 0, b_eu = 0;
    logic [11:0] b_ad = '0;
    logic [DW-1:0] b_md = '0;
    logic [31:0] rdata;
    logic [DW-1:0] mdo;

    ecc_err_mon #(.DATA_W(DW), .ADDR_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(b_wr), .reg_rd(b_rd), .reg_sel(b_sel),
        .reg_wdata(b_wd), .reg_rdata(rdata), .addr_mode(b_am), .mem_wr(b_mw),
        .mem_rd(b_mr), .mem_is_rx(b_rx), .mem_is_data(b_dt), .mem_addr(b_ad),
        .mem_wdata(b_md), .mem_wdata_out(mdo), .err_corr(b_ec), .err_uncorr(b_eu));

    int checks = 0, fails = 0, cycles = 0;
    // reference model state
    int m_c = 0, m_u = 0, m_lfa = 0, m_p1 = 0, m_p2 = 0;
    bit m_en = 0, m_sofe = 0, m_lock = 0;
    bit [3:0] m_arm = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] exp_out();
        logic [DW-1:0] d = b_md;
        int idx = {b_rx, b_dt};
        if (b_mw && m_arm[idx]) begin
            if (m_p1 != 255 && m_p1 < DW) d[m_p1] = ~b_md[m_p1];
            if (m_p2 != 255 && m_p2 < DW) d[m_p2] = ~b_md[m_p2];
        end
        return d;
    endfunction

    // Compare this cycle's outputs, advance the model, then go to the next falling edge.
    task automatic cyc();
        int idx;
        bit hc, hu, fail;
        #1;
        if (!b_sel) begin
            chk("R2 ccnt", rdata[7:0], 64'(m_c));
            chk("R3 ucnt", rdata[15:8], 64'(m_u));
            chk("R5 ctrl", rdata[19:16], {62'b0, m_sofe, m_en} );
            chk("R6 lfa", rdata[31:20], 64'(m_lfa));
        end else begin
            chk("R7 arm", rdata[15:0], 64'(m_arm));
            chk("R8 pos", rdata[31:16], 64'((m_p2 << 8) | m_p1));
        end
        chk("R8 wdata_out", mdo, exp_out());
        hc = m_en && b_ec;
        hu = m_en && b_eu;
        fail = m_en && b_mr && (b_ec || b_eu);
        if (b_rd && !b_sel) begin
            m_c = hc; m_u = hu;
        end else begin
            if (hc && m_c < 255) m_c++;
            if (hu && m_u < 255) m_u++;
        end
        if (!m_sofe) m_lock = 0;
        else if (fail && !m_lock) begin m_lock = 1; m_lfa = b_ad; end
        idx = {b_rx, b_dt};
        if (b_wr && b_sel) begin
            m_arm = b_wd[3:0]; m_p1 = b_wd[23:16]; m_p2 = b_wd[31:24];
        end else if (b_mw && m_arm[idx] && !b_am) m_arm[idx] = 0;
        if (b_wr && !b_sel) begin m_en = b_wd[16]; m_sofe = b_wd[17]; end
        @(posedge clk); @(negedge clk);
        {b_wr, b_rd, b_mw, b_mr, b_ec, b_eu} = '0;
    endtask

    task automatic regw(input logic sel, input logic [31:0] d);
        b_wr = 1; b_sel = sel; b_wd = d; cyc();
    endtask
    task automatic stat_rd();
        b_rd = 1; b_sel = 0; cyc();
    endtask
    task automatic err(input logic c, input logic u, input logic rd, input logic [11:0] a);
        b_ec = c; b_eu = u; b_mr = rd; b_ad = a; cyc();
    endtask
    task automatic mwr(input logic rx, input logic dt, input logic [DW-1:0] d);
        b_mw = 1; b_rx = rx; b_dt = dt; b_md = d; cyc();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state of both registers and pass-through data
        b_sel = 0; #1 chk("R1 status", rdata, 0);
        b_sel = 1; #1 chk("R1 inject", rdata, 0);
        b_mw = 1; b_md = 64'hA5A5; #1 chk("R1 wdata_out", mdo, 64'hA5A5);
        b_mw = 0;
        @(negedge clk);
        // R2/R3: counts ignored while disabled
        b_sel = 0; err(1, 1, 0, 0); err(1, 0, 0, 0);
        regw(0, 32'h0001_0000);
        for (int i = 0; i < 270; i++) err(1, i[0], 0, 0);
        chk("R2 saturate", rdata[7:0], 8'hFF);
        // R4: read clears; coincident error yields 1
        stat_rd();
        chk("R4 clear", rdata[15:0], 0);
        b_ec = 1; b_eu = 1; b_rd = 1; cyc();
        chk("R4 clear+hit", rdata[15:0], 16'h0101);
        // R5: writing counts/address/reserved fields has no effect
        regw(0, 32'hFFFF_FFFF);
        chk("R5 ro fields", rdata, 32'h0003_0101);
        // R6: capture first failing read address, then hold
        err(0, 0, 1, 12'h111);
        err(1, 0, 1, 12'h2AB);
        err(0, 1, 1, 12'h3CD);
        chk("R6 first capture", rdata[31:20], 12'h2AB);
        regw(0, 32'h0001_0000);
        err(1, 0, 1, 12'h444);
        chk("R6 held after clear", rdata[31:20], 12'h2AB);
        regw(0, 32'h0003_0000);
        err(0, 1, 1, 12'h555);
        chk("R6 rearm", rdata[31:20], 12'h555);
        // R7/R8: inject on Rx data only, positions 3 and 3 (single flip)
        regw(1, 32'h0303_0008);
        mwr(0, 1, 64'h0);
        mwr(1, 0, 64'h0);
        b_sel = 1;
        mwr(1, 1, 64'h0);
        chk("R7 consumed", rdata[3:0], 4'h0);
        // two positions, one 0xFF; addr_mode keeps the bit
        regw(1, 32'hFF05_0001);
        b_am = 1;
        b_mw = 1; b_rx = 0; b_dt = 0; b_md = 64'hF0; #1 chk("R8 one flip", mdo, 64'hD0);
        cyc(); cyc();
        chk("R7 addr_mode hold", rdata[3:0], 4'h1);
        b_am = 0;
        regw(1, 32'h3F00_000F);
        for (int k = 0; k < 4; k++) mwr(k[1], k[0], 64'h1234_5678_9ABC_DEF0);
        chk("R7 all consumed", rdata[3:0], 4'h0);
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom;
            b_sel = r[0]; b_am = r[1] & r[2];
            b_rd = (r[7:3] == 0);
            b_wr = (r[12:8] == 0);
            b_wd = $urandom;
            if (b_wr && b_sel && r[13]) b_wd[31:24] = 8'hFF;
            if (b_wr && b_sel && r[14]) b_wd[23:16] = b_wd[23:16] & 8'h3F;
            if (b_wr && b_sel && r[15]) b_wd[31:24] = b_wd[31:24] & 8'h3F;
            b_mw = r[16]; b_mr = r[17]; b_rx = r[18]; b_dt = r[19];
            b_ec = r[20] & r[21]; b_eu = r[22] & r[23] & r[24];
            b_ad = r[31:20];
            b_md = {$urandom, $urandom};
            cyc();
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule